// File: doc/BRIEF.md
# Hierarchical Predecoded Address Decoder

This block turns a flat memory address into the one-hot select signals that drive a memory array built from several equal blocks. The address is read as three fields: a block number in the top bits, a row number in the middle bits and a column number in the low bits. The block field picks the single active block. Every other block has its wordlines and column selects held low, so only one block draws switching power on an access.

Row decoding has two levels. The row field is cut into 2-bit slices. Each slice drives a small predecoder that raises one of four lines. If the row width is odd, the top slice is a single bit and raises one of two lines. A wordline rises only when its own line in every predecode group is high. The column field is decoded once. Each sub-block of the active block receives the same one-hot column select, so one column is picked per sub-block for each output bit. A global enable forces every output to zero. A parameter adds an optional output register stage with asynchronous reset. It is built as the wide, fast end of the select path just ahead of the array.

Top module: `hier_addr_decoder`

## Requirements
- R1: The address is read as block field in bits [ADDR_W-1 : ROW_W+COL_W], row field in bits [ROW_W+COL_W-1 : COL_W] and column field in bits [COL_W-1 : 0].
- R2: With enable high, exactly one bit of blk_en_o is high, namely bit number equal to the block field; with enable low none is.
- R3: Wordlines and column selects of every block other than the addressed one are always zero.
- R4: Each predecode group of two row bits raises exactly one of its four lines while enabled: line k for slice value k, slice g being row bits [2g+1:2g].
- R5: Within the addressed block exactly one wordline is high, at index b*2^ROW_W + r in wl_o (b block field, r row field), the AND of one line from every predecode group.
- R6: Within the addressed block every sub-block s raises exactly one column select, at index (b*SUB_N + s)*2^COL_W + c in csel_o (c column field).
- R7: With en_i low, blk_en_o, wl_o and csel_o are all zero whatever the address.
- R8: When ROW_W is odd, the top row bit forms a 1-of-2 group; its two upper predecode positions stay zero, and rows with that bit set and clear are both reachable.
- R9: With REG_OUT=1, outputs follow the inputs one clock later and are all zero while rst_ni is low; with REG_OUT=0 they follow the inputs directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset of the output register |
| en_i | input | 1 | Global enable; low forces all selects to zero |
| addr_i | input | BLK_W+ROW_W+COL_W | Flat address: block, row, column fields from top to bottom |
| blk_en_o | output | 2^BLK_W | One-hot block enable |
| wl_o | output | 2^BLK_W * 2^ROW_W | Wordlines, block-major |
| csel_o | output | 2^BLK_W * SUB_N * 2^COL_W | Column selects, block, then sub-block, then column |

## Verification
The bench builds the block with its defaults: four blocks, a 5-bit row field, a 2-bit column field, four sub-blocks and the registered output stage. The odd row width places a 1-of-2 group on top of two full 1-of-4 groups, so both predecoder shapes and their AND are exercised. It also brings all 128 wordlines and 64 column selects within reach of a few thousand random addresses. Because the register is present, the one-cycle latency, the reset value and the enable gating can all be observed at the ports.

// File: rtl/hdec_pkg.sv
package hdec_pkg;
  // number of predecode groups for a row field of width w
  function automatic int unsigned n_groups(int unsigned w);
    return (w + 1) / 2;
  endfunction

  // width of predecode group g (2 except an odd top group)
  function automatic int unsigned group_w(int unsigned w, int unsigned g);
    return ((w % 2 == 1) && (g == n_groups(w) - 1)) ? 1 : 2;
  endfunction
endpackage

// File: rtl/hdec_onehot.sv
module hdec_onehot #(
  parameter int unsigned W = 2
) (
  input  logic              en_i,
  input  logic [W-1:0]      sel_i,
  output logic [(1<<W)-1:0] y_o
);
  localparam int unsigned N = 1 << W;

  always_comb begin
    y_o = '0;
    for (int unsigned i = 0; i < N; i++) begin
      y_o[i] = en_i && (sel_i == W'(i));
    end
  end
endmodule

// File: rtl/hdec_predec.sv
module hdec_predec
  import hdec_pkg::*;
#(
  parameter int unsigned ROW_W = 5
) (
  input  logic                          en_i,
  input  logic [ROW_W-1:0]              row_i,
  output logic [4*n_groups(ROW_W)-1:0]  pd_o
);
  localparam int unsigned G = n_groups(ROW_W);

  for (genvar g = 0; g < G; g++) begin : g_grp
    localparam int unsigned GW = group_w(ROW_W, g);
    logic [(1<<GW)-1:0] lines;

    hdec_onehot #(.W(GW)) u_grp (
      .en_i  (en_i),
      .sel_i (row_i[2*g +: GW]),
      .y_o   (lines)
    );

    if (GW == 2) begin : g_full
      assign pd_o[4*g +: 4] = lines;
    end else begin : g_half
      assign pd_o[4*g +: 2]     = lines;
      assign pd_o[4*g + 2 +: 2] = 2'b00;
    end
  end
endmodule

// File: rtl/hdec_wl_and.sv
module hdec_wl_and
  import hdec_pkg::*;
#(
  parameter int unsigned ROW_W = 5
) (
  input  logic [4*n_groups(ROW_W)-1:0] pd_i,
  output logic [(1<<ROW_W)-1:0]        wl_o
);
  localparam int unsigned G    = n_groups(ROW_W);
  localparam int unsigned NROW = 1 << ROW_W;

  always_comb begin
    for (int unsigned r = 0; r < NROW; r++) begin
      logic acc;
      acc = 1'b1;
      for (int unsigned g = 0; g < G; g++) begin
        acc = acc & pd_i[4*g + ((r >> (2*g)) & 3)];
      end
      wl_o[r] = acc;
    end
  end
endmodule

// File: rtl/hier_addr_decoder.sv
module hier_addr_decoder
  import hdec_pkg::*;
#(
  parameter int unsigned BLK_W   = 2,
  parameter int unsigned ROW_W   = 5,
  parameter int unsigned COL_W   = 2,
  parameter int unsigned SUB_N   = 4,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  en_i,
  input  logic [BLK_W+ROW_W+COL_W-1:0]          addr_i,
  output logic [(1<<BLK_W)-1:0]                 blk_en_o,
  output logic [(1<<BLK_W)*(1<<ROW_W)-1:0]      wl_o,
  output logic [(1<<BLK_W)*SUB_N*(1<<COL_W)-1:0] csel_o
);
  localparam int unsigned NBLK = 1 << BLK_W;
  localparam int unsigned NROW = 1 << ROW_W;
  localparam int unsigned NCOL = 1 << COL_W;
  localparam int unsigned G    = n_groups(ROW_W);
  localparam int unsigned WL_N = NBLK * NROW;
  localparam int unsigned CS_N = NBLK * SUB_N * NCOL;

  logic [BLK_W-1:0] blk_f;
  logic [ROW_W-1:0] row_f;
  logic [COL_W-1:0] col_f;

  assign col_f = addr_i[COL_W-1:0];
  assign row_f = addr_i[COL_W +: ROW_W];
  assign blk_f = addr_i[COL_W+ROW_W +: BLK_W];

  logic [NBLK-1:0] blk_d;
  logic [4*G-1:0]  pd;
  logic [NROW-1:0] wl_core;
  logic [NCOL-1:0] col_core;
  logic [WL_N-1:0] wl_d;
  logic [CS_N-1:0] cs_d;

  hdec_onehot #(.W(BLK_W)) u_blk (
    .en_i  (en_i),
    .sel_i (blk_f),
    .y_o   (blk_d)
  );

  hdec_predec #(.ROW_W(ROW_W)) u_predec (
    .en_i  (en_i),
    .row_i (row_f),
    .pd_o  (pd)
  );

  hdec_wl_and #(.ROW_W(ROW_W)) u_wl (
    .pd_i (pd),
    .wl_o (wl_core)
  );

  hdec_onehot #(.W(COL_W)) u_col (
    .en_i  (en_i),
    .sel_i (col_f),
    .y_o   (col_core)
  );

  // only the addressed block sees wordlines and column selects
  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    assign wl_d[b*NROW +: NROW] = wl_core & {NROW{blk_d[b]}};
    for (genvar s = 0; s < SUB_N; s++) begin : g_sub
      assign cs_d[(b*SUB_N+s)*NCOL +: NCOL] = col_core & {NCOL{blk_d[b]}};
    end
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        blk_en_o <= '0;
        wl_o     <= '0;
        csel_o   <= '0;
      end else begin
        blk_en_o <= blk_d;
        wl_o     <= wl_d;
        csel_o   <= cs_d;
      end
    end

    // R7, R9: a disabled cycle yields all-zero outputs one clock later
    a_r7_disable_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (blk_en_o == '0 && wl_o == '0 && csel_o == '0));
    // R2: an enabled cycle yields exactly one block enable next clock
    a_r2_blk_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i |=> $onehot(blk_en_o));
    // R5: an enabled cycle yields exactly one wordline next clock
    a_r5_wl_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i |=> $onehot(wl_o));
    // R6: one column per sub-block of the selected block
    a_r6_csel_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i |=> ($countones(csel_o) == SUB_N));
  end else begin : g_comb
    assign blk_en_o = blk_d;
    assign wl_o     = wl_d;
    assign csel_o   = cs_d;

    a_r7_disable_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |-> (blk_en_o == '0 && wl_o == '0 && csel_o == '0));
    a_r2_blk_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i |-> $onehot(blk_en_o));
    a_r5_wl_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i |-> $onehot(wl_o));
    a_r6_csel_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i |-> ($countones(csel_o) == SUB_N));
  end

  // R4: each predecode group is one-hot while enabled
  for (genvar g = 0; g < G; g++) begin : g_pd_chk
    a_r4_group_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i |-> $onehot(pd[4*g +: 4]));
  end

  // R8: odd top group never drives its upper positions
  if (ROW_W % 2 == 1) begin : g_odd_chk
    a_r8_half_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pd[4*(G-1)+2 +: 2] == 2'b00);
  end

  // R3: the wordline core and the block enable agree on the enable
  a_r3_core_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_d == '0) |-> (wl_d == '0 && cs_d == '0));
endmodule

// File: tb/hier_addr_decoder_tb.sv
module hier_addr_decoder_tb;
  localparam int unsigned BLK_W  = 2;
  localparam int unsigned ROW_W  = 5;
  localparam int unsigned COL_W  = 2;
  localparam int unsigned SUB_N  = 4;
  localparam int unsigned ADDR_W = BLK_W + ROW_W + COL_W;
  localparam int unsigned NBLK   = 1 << BLK_W;
  localparam int unsigned NROW   = 1 << ROW_W;
  localparam int unsigned NCOL   = 1 << COL_W;
  localparam int unsigned WL_N   = NBLK * NROW;
  localparam int unsigned CS_N   = NBLK * SUB_N * NCOL;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [NBLK-1:0]   blk_en;
  logic [WL_N-1:0]   wl;
  logic [CS_N-1:0]   csel;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  hier_addr_decoder #(
    .BLK_W(BLK_W), .ROW_W(ROW_W), .COL_W(COL_W), .SUB_N(SUB_N), .REG_OUT(1'b1)
  ) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .en_i    (en),
    .addr_i  (addr),
    .blk_en_o(blk_en),
    .wl_o    (wl),
    .csel_o  (csel)
  );

  function automatic logic [NBLK-1:0] exp_blk(logic e, logic [ADDR_W-1:0] a);
    logic [NBLK-1:0] v = '0;
    if (e) v[a[ADDR_W-1 -: BLK_W]] = 1'b1;
    return v;
  endfunction

  function automatic logic [WL_N-1:0] exp_wl(logic e, logic [ADDR_W-1:0] a);
    logic [WL_N-1:0] v = '0;
    int unsigned b = a[ADDR_W-1 -: BLK_W];
    int unsigned r = a[COL_W +: ROW_W];
    if (e) v[b*NROW + r] = 1'b1;
    return v;
  endfunction

  function automatic logic [CS_N-1:0] exp_cs(logic e, logic [ADDR_W-1:0] a);
    logic [CS_N-1:0] v = '0;
    int unsigned b = a[ADDR_W-1 -: BLK_W];
    int unsigned c = a[COL_W-1:0];
    if (e) for (int unsigned s = 0; s < SUB_N; s++) v[(b*SUB_N+s)*NCOL + c] = 1'b1;
    return v;
  endfunction

  task automatic check(string req, logic e, logic [ADDR_W-1:0] a);
    n_chk++;
    if (blk_en !== exp_blk(e, a) || wl !== exp_wl(e, a) || csel !== exp_cs(e, a)) begin
      n_bad++;
      $display("FAIL %s addr=%h en=%b blk=%h/%h wl=%h/%h csel=%h/%h", req, a, e,
               blk_en, exp_blk(e, a), wl, exp_wl(e, a), csel, exp_cs(e, a));
    end
  endtask

  // drive at negedge, register at posedge, check at following negedge
  task automatic apply(string req, logic e, logic [ADDR_W-1:0] a);
    en = e;
    addr = a;
    @(posedge clk);
    @(negedge clk);
    check(req, e, a);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R9: reset state, with inputs active during reset
    en = 1'b1;
    addr = 9'h1ff;
    repeat (3) @(negedge clk);
    check("R9_reset", 1'b0, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1, R5, R6 corner addresses
    apply("R1_zero", 1'b1, '0);
    apply("R1_ones", 1'b1, '1);
    for (int b = 0; b < NBLK; b++) begin
      // R2, R3: each block in turn
      apply("R2_block", 1'b1, ADDR_W'((b << (ROW_W+COL_W)) | 9'h05));
    end
    for (int r = 0; r < NROW; r++) begin
      // R4, R5, R8: every row, both halves of the odd top group
      apply("R5_row", 1'b1, ADDR_W'((2 << (ROW_W+COL_W)) | (r << COL_W) | 1));
    end
    for (int c = 0; c < NCOL; c++) begin
      apply("R6_col", 1'b1, ADDR_W'((1 << (ROW_W+COL_W)) | (7 << COL_W) | c));
    end
    apply("R8_top_set", 1'b1, ADDR_W'(16 << COL_W));
    apply("R8_top_clr", 1'b1, ADDR_W'(15 << COL_W));

    // R7: enable low with several addresses
    apply("R7_off_ones", 1'b0, '1);
    apply("R7_off_mid", 1'b0, 9'h0aa);
    apply("R7_on_again", 1'b1, 9'h0aa);

    // R9: output holds the previous value until the next edge
    apply("R9_prev", 1'b1, 9'h123);
    en = 1'b1;
    addr = 9'h0c4;
    #3;
    check("R9_hold", 1'b1, 9'h123);
    @(posedge clk);
    @(negedge clk);
    check("R9_next", 1'b1, 9'h0c4);

    // random mix, enable high about 7 of 8 times
    for (int i = 0; i < 3000; i++) begin
      logic [ADDR_W-1:0] a;
      logic e;
      a = ADDR_W'($urandom);
      e = ($urandom % 8) != 0;
      apply(e ? "R3_rand" : "R7_rand", e, a);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule